// File: doc/BRIEF.md
# Planar Intra Prediction Sample Generator

This block produces a square block of 8-bit predicted samples for video intra coding in planar mode. Each sample blends four reference values: the left neighbour of its row, the top neighbour of its column, the top-right corner and the bottom-left corner. Each value is weighted by the sample's distance from the opposite edge. The sum is rounded and divided by a power of two that depends on the block size.

A caller pulses `start` with the block edge length (4, 8, 16 or 32). It then writes the neighbouring reference samples into a flat internal array through an index/byte port, and pulses `ref_go`. The block then streams the prediction on a valid/ready port. Each beat carries up to eight samples, the row they belong to, and the column of the first sample. For an edge of 8 or more, the stream works through bands of eight rows. Within a band it covers eight-column strips from left to right, and each strip runs down the band's eight rows. A 4x4 block comes out as four beats of four samples, top row first.

Top module: `planar_pred`

## Requirements
- R1: After reset `out_valid`, `done` and `err` are 0.
- R2: A `start` pulse in the idle phase with `size_in` equal to 4, 8, 16 or 32 latches that size and opens the load phase. Any other size makes `err` high for exactly the next cycle, and no beat follows.
- R3: In the load phase, `ref_we` stores `ref_data` at entry `ref_idx` of a flat reference array of 4*nt+1 bytes. A `ref_go` pulse in the load phase starts streaming on the next cycle. `ref_go` outside the load phase is ignored.
- R4: A `start` pulse is ignored while a block is loading or streaming. The latched size and the output sequence stay unchanged.
- R5: The reference index layout is fixed. The left sample of row y is at index 2nt-1-y and the top sample of column x is at 2nt+1+x. The top-right corner is at 3nt+1 and the bottom-left corner is at nt-1.
- R6: The sample at (x, y) is ((nt-1-x)*left(y) + (x+1)*topright + (nt-1-y)*top(x) + (y+1)*bottomleft + nt) >> (log2(nt)+1), truncated to 8 bits. Lane l of `out_data` (bits 8l+7..8l) holds column `out_col`+l of row `out_row`.
- R7: For nt of 8 or more, beats come in this order: 8-row bands from top to bottom; within a band, 8-column strips from left to right; within a strip, rows from top to bottom. `out_col` is a multiple of 8.
- R8: For nt = 4, four beats come out for rows 0 to 3 with `out_col` = 0. `out_mask` is 8'h0F and lanes 4..7 of `out_data` are 0.
- R9: For nt of 8 or more, `out_mask` is 8'hFF on every beat.
- R10: While `out_valid` is high and `out_ready` is low, `out_data`, `out_row`, `out_col` and `out_mask` hold their values and `out_valid` stays high.
- R11: `done` is high for exactly one cycle, the cycle after the final beat is accepted. The block then returns to idle and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new block (idle phase only) |
| size_in | input | 6 | Block edge length, sampled with start |
| ref_we | input | 1 | Reference write strobe |
| ref_idx | input | 8 | Reference array index |
| ref_data | input | 8 | Reference sample value |
| ref_go | input | 1 | Loading finished, begin streaming |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 64 | Eight 8-bit sample lanes |
| out_mask | output | 8 | Per-lane valid flags |
| out_row | output | 5 | Row of the beat |
| out_col | output | 5 | Column of lane 0 |
| done | output | 1 | One-cycle pulse after the last beat |
| err | output | 1 | One-cycle pulse on an unsupported size |

## Verification
The bench builds the block with its default parameters: a maximum edge of 32 and eight lanes. With these, every supported size can be run in full, and every beat of every block is compared against the formula. Each size gets random, all-zero, all-255 and ramp reference arrays. The all-255 case drives the weighted sum to its largest value. The consumer's ready is randomised, so held beats are compared again. Misplaced start pulses, a stray ref_go and out-of-range sizes are also applied, so the ignore and reject paths are checked at the ports.

// File: rtl/planar_pkg.sv
package planar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_STREAM = 2'd2
    } phase_e;
endpackage

// File: rtl/planar_refbuf.sv
module planar_refbuf #(
    parameter int REF_N = 129,
    parameter int IDX_W = 8,
    parameter int SW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  logic [SW-1:0]               data,
    output logic [REF_N-1:0][SW-1:0]    mem_o
);
    logic [REF_N-1:0][SW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(idx) < REF_N)) begin
            mem_d[idx] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign mem_o = mem_q;
endmodule

// File: rtl/planar_lane.sv
module planar_lane #(
    parameter int NT_W  = 6,
    parameter int POS_W = 5,
    parameter int SW    = 8,
    parameter int ACC_W = 16
) (
    input  logic [NT_W-1:0]  nt,
    input  logic [3:0]       shamt,
    input  logic [POS_W-1:0] x,
    input  logic [POS_W-1:0] y,
    input  logic [SW-1:0]    left_s,
    input  logic [SW-1:0]    top_s,
    input  logic [SW-1:0]    tr_s,
    input  logic [SW-1:0]    bl_s,
    output logic [SW-1:0]    pix
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

    logic [ACC_W-1:0] nt_w, x_w, y_w, sum;

    always_comb begin
        nt_w = ACC_W'(nt);
        x_w  = ACC_W'(x);
        y_w  = ACC_W'(y);
        sum  = (nt_w - ONE - x_w) * ACC_W'(left_s)
             + (x_w + ONE)        * ACC_W'(tr_s)
             + (nt_w - ONE - y_w) * ACC_W'(top_s)
             + (y_w + ONE)        * ACC_W'(bl_s)
             + nt_w;
        pix  = SW'(sum >> shamt);
    end
endmodule

// File: rtl/planar_seq.sv
module planar_seq
    import planar_pkg::*;
#(
    parameter int MAX_NT = 32,
    parameter int LANES  = 8,
    parameter int NT_W   = 6,
    parameter int POS_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NT_W-1:0]  size_in,
    input  logic             ref_go,
    input  logic             take,
    output phase_e           phase_o,
    output logic [NT_W-1:0]  nt_o,
    output logic [NT_W-1:0]  grp_o,
    output logic [3:0]       shamt_o,
    output logic [POS_W-1:0] row_o,
    output logic [POS_W-1:0] col_o,
    output logic             done_o,
    output logic             err_o
);
    typedef struct packed {
        phase_e          phase;
        logic [NT_W-1:0] nt;
        logic [3:0]      shamt;
        logic [NT_W-1:0] rbase;
        logic [NT_W-1:0] cbase;
        logic [NT_W-1:0] rsub;
        logic            done;
        logic            err;
    } seq_t;

    seq_t s_d, s_q;
    logic            size_ok;
    logic [3:0]      lg;
    logic [NT_W-1:0] grp;

    always_comb begin
        lg = '0;
        for (int i = 0; i < NT_W; i++) begin
            if (size_in[i]) lg = 4'(i);
        end
        size_ok = ($countones(size_in) == 1) && (size_in >= NT_W'(4))
                  && (size_in <= NT_W'(MAX_NT));
        grp = (s_q.nt < NT_W'(LANES)) ? s_q.nt : NT_W'(LANES);

        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (size_ok) begin
                        s_d.phase = PH_LOAD;
                        s_d.nt    = size_in;
                        s_d.shamt = lg + 4'd1;
                        s_d.rbase = '0;
                        s_d.cbase = '0;
                        s_d.rsub  = '0;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_LOAD: begin
                if (ref_go) s_d.phase = PH_STREAM;
            end
            PH_STREAM: begin
                if (take) begin
                    if (s_q.rsub == grp - NT_W'(1)) begin
                        s_d.rsub = '0;
                        if (s_q.cbase + grp >= s_q.nt) begin
                            s_d.cbase = '0;
                            if (s_q.rbase + grp >= s_q.nt) begin
                                s_d.phase = PH_IDLE;
                                s_d.done  = 1'b1;
                            end else begin
                                s_d.rbase = s_q.rbase + grp;
                            end
                        end else begin
                            s_d.cbase = s_q.cbase + grp;
                        end
                    end else begin
                        s_d.rsub = s_q.rsub + NT_W'(1);
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, nt: NT_W'(4), shamt: 4'd3, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign nt_o    = s_q.nt;
    assign grp_o   = grp;
    assign shamt_o = s_q.shamt;
    assign row_o   = POS_W'(s_q.rbase + s_q.rsub);
    assign col_o   = POS_W'(s_q.cbase);
    assign done_o  = s_q.done;
    assign err_o   = s_q.err;
endmodule

// File: rtl/planar_pred.sv
module planar_pred
    import planar_pkg::*;
#(
    parameter int MAX_NT = 32,
    parameter int LANES  = 8,
    parameter int SW     = 8,
    parameter int NT_W   = $clog2(MAX_NT) + 1,
    parameter int POS_W  = $clog2(MAX_NT),
    parameter int REF_N  = 4 * MAX_NT + 1,
    parameter int IDX_W  = $clog2(REF_N),
    parameter int ACC_W  = SW + NT_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NT_W-1:0]       size_in,
    input  logic                  ref_we,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic [SW-1:0]         ref_data,
    input  logic                  ref_go,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*SW-1:0]   out_data,
    output logic [LANES-1:0]      out_mask,
    output logic [POS_W-1:0]      out_row,
    output logic [POS_W-1:0]      out_col,
    output logic                  done,
    output logic                  err
);
    localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

    phase_e                   phase;
    logic [NT_W-1:0]          nt, grp;
    logic [3:0]               shamt;
    logic [POS_W-1:0]         row, col;
    logic [REF_N-1:0][SW-1:0] mem;
    logic [IDX_W-1:0]         nt_i, left_idx, tr_idx, bl_idx;
    logic [SW-1:0]            left_s, tr_s, bl_s;

    planar_seq #(
        .MAX_NT(MAX_NT), .LANES(LANES), .NT_W(NT_W), .POS_W(POS_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .size_in(size_in),
        .ref_go(ref_go), .take(out_valid && out_ready),
        .phase_o(phase), .nt_o(nt), .grp_o(grp), .shamt_o(shamt),
        .row_o(row), .col_o(col), .done_o(done), .err_o(err)
    );

    planar_refbuf #(.REF_N(REF_N), .IDX_W(IDX_W), .SW(SW)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(ref_we && (phase == PH_LOAD)),
        .idx(ref_idx), .data(ref_data), .mem_o(mem)
    );

    always_comb begin
        nt_i     = IDX_W'(nt);
        left_idx = (nt_i << 1) - ONE_I - IDX_W'(row);
        tr_idx   = (nt_i << 1) + nt_i + ONE_I;
        bl_idx   = nt_i - ONE_I;
        left_s   = mem[left_idx];
        tr_s     = mem[tr_idx];
        bl_s     = mem[bl_idx];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [POS_W-1:0] x;
        logic [IDX_W-1:0] top_idx;
        logic [SW-1:0]    pix;
        logic             on;

        assign x       = col + POS_W'(l);
        assign top_idx = (nt_i << 1) + ONE_I + IDX_W'(col) + IDX_W'(l);
        assign on      = NT_W'(l) < grp;

        planar_lane #(.NT_W(NT_W), .POS_W(POS_W), .SW(SW), .ACC_W(ACC_W)) u_lane (
            .nt(nt), .shamt(shamt), .x(x), .y(row),
            .left_s(left_s), .top_s(mem[top_idx]), .tr_s(tr_s), .bl_s(bl_s),
            .pix(pix)
        );

        assign out_data[l*SW +: SW] = on ? pix : '0;
        assign out_mask[l]          = on;
    end

    assign out_valid = (phase == PH_STREAM);
    assign out_row   = row;
    assign out_col   = col;
endmodule

// File: rtl/planar_pred_chk.sv
module planar_pred_chk #(
    parameter int LANES = 8,
    parameter int SW    = 8,
    parameter int POS_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                out_valid,
    input logic                out_ready,
    input logic [LANES*SW-1:0] out_data,
    input logic [LANES-1:0]    out_mask,
    input logic [POS_W-1:0]    out_row,
    input logic [POS_W-1:0]    out_col,
    input logic                done,
    input logic                err
);
    localparam logic [LANES-1:0] HALF = {(LANES/2){1'b1}};

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_row) && $stable(out_col) && $stable(out_mask));

    // R8 and R9: only the two legal lane patterns appear
    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask == '1 || out_mask == HALF));

    assert_done_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready) && !out_valid);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid && !done);

    assert_err_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind planar_pred planar_pred_chk #(.LANES(LANES), .SW(SW), .POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mask(out_mask), .out_row(out_row),
    .out_col(out_col), .done(done), .err(err)
);

// File: tb/test_planar_pred.sv
module test_planar_pred;
    localparam int REF_N = 129;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  size_in = '0;
    logic        ref_we = 1'b0;
    logic [7:0]  ref_idx = '0;
    logic [7:0]  ref_data = '0;
    logic        ref_go = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_mask;
    logic [4:0]  out_row, out_col;
    logic        done, err;

    int n_cmp = 0;
    int n_bad = 0;
    int refv [REF_N];

    always #2 clk = ~clk;

    planar_pred i_planar_pred (
        .clk(clk), .rst_n(rst_n), .start(start), .size_in(size_in),
        .ref_we(ref_we), .ref_idx(ref_idx), .ref_data(ref_data), .ref_go(ref_go),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_mask(out_mask), .out_row(out_row), .out_col(out_col),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int lg2(input int n);
        int r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    function automatic int model(input int nt, input int x, input int y);
        int s;
        s = (nt - 1 - x) * refv[2*nt - 1 - y] + (x + 1) * refv[3*nt + 1]
          + (nt - 1 - y) * refv[2*nt + 1 + x] + (y + 1) * refv[nt - 1] + nt;
        return (s >> (lg2(nt) + 1)) & 255;
    endfunction

    // mode 0 random, 1 all 255, 2 all 0, 3 ramp; poke adds misplaced starts (R4)
    task automatic run_block(input int nt, input int mode, input bit poke);
        int g, strips, nbeats, k;
        for (int i = 0; i < REF_N; i++) begin
            case (mode)
                0: refv[i] = int'($urandom_range(0, 255));
                1: refv[i] = 255;
                2: refv[i] = 0;
                default: refv[i] = (i * 7) & 255;
            endcase
        end
        start = 1'b1; size_in = 6'(nt);
        tick();
        start = 1'b0;
        for (int i = 0; i <= 4*nt; i++) begin
            ref_we = 1'b1; ref_idx = 8'(i); ref_data = 8'(refv[i]);
            if (poke && i == 2) begin start = 1'b1; size_in = 6'd4; end
            tick();
            start = 1'b0;
        end
        ref_we = 1'b0;
        ref_go = 1'b1;
        tick();
        ref_go = 1'b0;
        g = (nt < 8) ? nt : 8;
        strips = nt / g;
        nbeats = (nt * nt) / g;
        k = 0;
        while (k < nbeats) begin
            int er, ec, rg, rs, st;
            longint ed;
            bit ok;
            rs = k % g; st = (k / g) % strips; rg = k / (g * strips);
            er = rg * g + rs; ec = st * g;
            out_ready = ($urandom_range(0, 3) != 0);
            start = (poke && k == 3);
            size_in = 6'd8;
            #0.5;
            ed = 0;
            for (int l = 0; l < g; l++) ed |= longint'(model(nt, ec + l, er)) << (8*l);
            check(out_valid == 1'b1, "R3", "valid in stream", longint'(out_valid), 1);
            check(out_data == 64'(ed), "R6", "sample lanes", longint'(out_data), ed);
            ok = (int'(out_row) == er) && (int'(out_col) == ec);
            check(ok, (nt == 4) ? "R8" : "R7", "row/col tag",
                  longint'({out_row, 3'b0, out_col}), longint'({5'(er), 3'b0, 5'(ec)}));
            check(out_mask == ((nt == 4) ? 8'h0F : 8'hFF), (nt == 4) ? "R8" : "R9",
                  "lane mask", longint'(out_mask), (nt == 4) ? 15 : 255);
            if (out_ready) k++;
            tick();
            start = 1'b0;
        end
        out_ready = 1'b0;
        check(done == 1'b1 && out_valid == 1'b0, "R11", "done after last beat",
              longint'({done, out_valid}), 2);
        tick();
        check(done == 1'b0, "R11", "done single cycle", longint'(done), 0);
        // R5: a wrong left/top/corner index would break the R6 checks above
    endtask

    task automatic bad_size(input int sz);
        start = 1'b1; size_in = 6'(sz);
        tick();
        start = 1'b0;
        check(err == 1'b1 && out_valid == 1'b0, "R2", "err on bad size",
              longint'({err, out_valid}), 2);
        tick();
        check(err == 1'b0, "R2", "err single cycle", longint'(err), 0);
        ref_go = 1'b1;
        tick();
        ref_go = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(out_valid == 1'b0, "R3", "ref_go in idle ignored", longint'(out_valid), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "reset outputs",
              longint'({out_valid, done, err}), 0);
        rst_n = 1'b1;
        tick();
        check(out_valid == 1'b0, "R1", "idle after reset", longint'(out_valid), 0);
        bad_size(12);
        bad_size(2);
        bad_size(0);
        bad_size(63);
        for (int s = 4; s <= 32; s = s * 2) begin
            for (int m = 0; m < 4; m++) run_block(s, m, 1'b0);
        end
        run_block(16, 0, 1'b1);   // R4 start during load and stream
        run_block(8, 0, 1'b1);    // R4
        run_block(4, 3, 1'b1);    // R4
        for (int i = 0; i < 3; i++) run_block(32, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule